// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block holds the processor's current interrupt priority level, a 3-bit value from 0 to 7. It decides whether a pending interrupt request may be taken. A request is admitted only when its own level is strictly above the current level. When the sequencer accepts the request, the block presents the old level so that it can be pushed to the stack, and on the next clock edge it adopts the accepted request's level.

Software has no direct write path to the level. The only ways to change it are acceptance, or a restore that loads a level popped from the stack when a status word is pulled back. Choosing among several request sources, and the stack storage, are handled by neighbouring logic.

Each cycle falls into one of three named operations, decoded by the sequencer stage.
- HOLD: no change.
- TAKE: an admitted request is accepted.
- RESTORE: a popped level is loaded. RESTORE takes precedence over TAKE.

The transitions between operations are:
- HOLD→TAKE when `accept_stb` meets an asserted `grant_ok`.
- Any→RESTORE whenever `restore_ld` is high.
- Back to HOLD when neither condition is present.

Top module: `ipl_gate`

## Requirements
- R1: While reset is asserted, and after it is released, `cur_level` reads 0 until a TAKE or RESTORE occurs.
- R2: `grant_ok` is 1 exactly when `req_valid` is 1, `req_level` is numerically greater than `cur_level`, and `restore_ld` is 0.
- R3: A request at level 0 never raises `grant_ok`, whatever the current level.
- R4: `save_level` equals `cur_level` in the cycle where `accept_stb` and `grant_ok` are both high.
- R5: When `accept_stb` and `grant_ok` are both 1 and `restore_ld` is 0 (TAKE), `cur_level` equals that cycle's `req_level` after the next rising clock edge.
- R6: An `accept_stb` while `grant_ok` is 0 has no effect on `cur_level`.
- R7: When `restore_ld` is 1 (RESTORE), `cur_level` equals that cycle's `restore_level` after the next rising clock edge.
- R8: When `restore_ld` and `accept_stb` are high together, the restore value is loaded and `grant_ok` is 0, so the request is not taken.
- R9: With `accept_stb` and `restore_ld` both 0 (HOLD), `cur_level` keeps its value whatever happens on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An interrupt request is pending |
| req_level | input | 3 | Priority level of the pending request |
| accept_stb | input | 1 | The sequencer takes the request this cycle |
| restore_ld | input | 1 | Load a level popped from the stack |
| restore_level | input | 3 | Popped level value |
| grant_ok | output | 1 | The request may be accepted |
| save_level | output | 3 | Level to push on acceptance |
| cur_level | output | 3 | Current priority level |

## Verification
The request level is swept against every current level, so the strict-greater test is checked at equality as well as one level above and one level below. Level-0 requests are issued at level 0 to show that they can never enter. Strobes that land on a refused request show that acceptance is gated rather than following the strobe alone. Cycles where a restore and an accept coincide show which of the two wins. Random mixes of request, strobe and restore then move the level through many values, so that an update taken from the wrong source produces a wrong level.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    parameter int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_TAKE    = 2'd1,
        OP_RESTORE = 2'd2
    } lvl_op_e;
endpackage

// File: rtl/ipl_cmp.sv
module ipl_cmp
    import ipl_pkg::*;
(
    input  logic req_valid,
    input  lvl_t req_level,
    input  lvl_t cur_level,
    output logic above
);
    always_comb begin
        above = req_valid && (req_level > cur_level);
    end
endmodule

// File: rtl/ipl_seq.sv
module ipl_seq
    import ipl_pkg::*;
(
    input  logic    above,
    input  logic    accept_stb,
    input  logic    restore_ld,
    output lvl_op_e op,
    output logic    grant_ok
);
    always_comb begin
        if (restore_ld)
            op = OP_RESTORE;
        else if (accept_stb && above)
            op = OP_TAKE;
        else
            op = OP_HOLD;
    end

    always_comb begin
        grant_ok = above && !restore_ld;
    end
endmodule

// File: rtl/ipl_reg.sv
module ipl_reg
    import ipl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  lvl_op_e op,
    input  lvl_t    take_level,
    input  lvl_t    pop_level,
    output lvl_t    level_q
);
    lvl_t level_d;

    always_comb begin
        unique case (op)
            OP_HOLD:    level_d = level_q;
            OP_TAKE:    level_d = take_level;
            OP_RESTORE: level_d = pop_level;
            default:    level_d = level_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= level_d;
    end
endmodule

// File: rtl/ipl_gate.sv
module ipl_gate
    import ipl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic             accept_stb,
    input  logic             restore_ld,
    input  logic [LVL_W-1:0] restore_level,
    output logic             grant_ok,
    output logic [LVL_W-1:0] save_level,
    output logic [LVL_W-1:0] cur_level
);
    logic    above;
    lvl_op_e op;
    lvl_t    level_q;

    ipl_cmp u_cmp (
        .req_valid (req_valid),
        .req_level (req_level),
        .cur_level (level_q),
        .above     (above)
    );

    ipl_seq u_seq (
        .above      (above),
        .accept_stb (accept_stb),
        .restore_ld (restore_ld),
        .op         (op),
        .grant_ok   (grant_ok)
    );

    ipl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .take_level (req_level),
        .pop_level  (restore_level),
        .level_q    (level_q)
    );

    assign cur_level  = level_q;
    assign save_level = level_q;
endmodule

// File: rtl/ipl_gate_chk.sv
module ipl_gate_chk
    import ipl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LVL_W-1:0] req_level,
    input logic             accept_stb,
    input logic             restore_ld,
    input logic [LVL_W-1:0] restore_level,
    input logic             grant_ok,
    input logic [LVL_W-1:0] save_level,
    input logic [LVL_W-1:0] cur_level
);
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> cur_level == '0);

    a_r2_strict_above: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ok |-> (req_valid && req_level > cur_level));

    a_r3_zero_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_level == '0) |-> !grant_ok);

    a_r4_save_old: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_stb && grant_ok) |-> save_level == cur_level);

    a_r5_take_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_stb && grant_ok && !restore_ld) |=> cur_level == $past(req_level));

    a_r6_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_stb && !grant_ok && !restore_ld) |=> $stable(cur_level));

    a_r7_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        restore_ld |=> cur_level == $past(restore_level));

    a_r8_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restore_ld |-> !grant_ok);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_stb && !restore_ld) |=> $stable(cur_level));
endmodule

bind ipl_gate ipl_gate_chk u_chk (.*);

// File: tb/ipl_gate_bench.sv
module ipl_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_level = '0;
    logic       accept_stb = 1'b0;
    logic       restore_ld = 1'b0;
    logic [2:0] restore_level = '0;
    logic       grant_ok;
    logic [2:0] save_level;
    logic [2:0] cur_level;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [2:0] exp_lvl = '0;
    string lvl_tag = "R1";

    always #4 clk = ~clk;

    ipl_gate u_ipl_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_level     (req_level),
        .accept_stb    (accept_stb),
        .restore_ld    (restore_ld),
        .restore_level (restore_level),
        .grant_ok      (grant_ok),
        .save_level    (save_level),
        .cur_level     (cur_level)
    );

    function automatic logic f_grant(logic v, logic [2:0] rl, logic [2:0] cl, logic rs);
        return v && (rl > cl) && !rs;
    endfunction

    function automatic logic [2:0] f_next(logic [2:0] cl, logic g, logic a, logic rs,
                                          logic [2:0] rl, logic [2:0] pl);
        if (rs) return pl;
        if (a && g) return rl;
        return cl;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(logic v, logic [2:0] rl, logic a, logic rs, logic [2:0] pl);
        logic eg;
        @(negedge clk);
        req_valid = v; req_level = rl; accept_stb = a;
        restore_ld = rs; restore_level = pl;
        #1;
        check(lvl_tag, cur_level, exp_lvl);
        eg = f_grant(v, rl, exp_lvl, rs);
        check(rs ? "R8" : (rl == 3'd0 ? "R3" : "R2"), grant_ok, eg);
        if (a && eg) check("R4", save_level, exp_lvl);
        if (rs) lvl_tag = "R7";
        else if (a && eg) lvl_tag = "R5";
        else if (a) lvl_tag = "R6";
        else lvl_tag = "R9";
        exp_lvl = f_next(exp_lvl, eg, a, rs, rl, pl);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1", cur_level, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 after release, R3 level-0 request at level 0
        step(1'b1, 3'd0, 1'b1, 1'b0, 3'd0);
        // R5 take level 5, R4 saved 0
        step(1'b1, 3'd5, 1'b1, 1'b0, 3'd0);
        // R2 equal level refused, R6 strobe ignored
        step(1'b1, 3'd5, 1'b1, 1'b0, 3'd0);
        step(1'b1, 3'd3, 1'b1, 1'b0, 3'd0);
        // one above
        step(1'b1, 3'd6, 1'b1, 1'b0, 3'd0);
        // R9 hold with request toggling
        step(1'b1, 3'd7, 1'b0, 1'b0, 3'd1);
        step(1'b0, 3'd7, 1'b1, 1'b0, 3'd1);
        // R8 restore and accept together
        step(1'b1, 3'd7, 1'b1, 1'b1, 3'd2);
        // R7 loaded 2, then request 7 admitted
        step(1'b1, 3'd7, 1'b1, 1'b0, 3'd0);
        // level 7 blocks everything
        step(1'b1, 3'd7, 1'b1, 1'b0, 3'd0);
        step(1'b1, 3'd0, 1'b0, 1'b1, 3'd0);
        step(1'b1, 3'd0, 1'b1, 1'b0, 3'd0);
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0),
                 3'($urandom_range(0, 7)));
        end
        step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule